// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block owns the 32-bit status word that sits beside a floating-point execution pipe. It turns two of the word's fields into live controls: a rounding direction and a flush-to-zero switch. It also absorbs the side effects of finished operations. When an arithmetic operation completes, its five exception flags are merged into sticky bits at the top of the word. A trap pulse is raised if any raised flag has its enable bit set.

When a compare completes, the block picks one outcome bit out of the compare's condition mask, using the relation result. It stores that bit either in one targeted condition bit or at the head of a compare queue that shifts by one place. Software can overwrite the whole word through a write port. The arithmetic itself happens elsewhere; this unit only records the results.

Top module: `fpsr_unit`

## Requirements
- R1: After reset the status word is zero and the trap output is low.
- R2: roundMode always equals status bits 10:9, with 0 nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity. flushZero always equals status bit 5, which covers both inputs and results.
- R3: On an operation-done cycle without a software write, the flag vector is ORed into status bits 31:27. The flags are inexact (opFlags bit 0, status bit 27), underflow (bit 1, 28), overflow (bit 2, 29), divide-by-zero (bit 3, 30) and invalid (bit 4, 31). Flag bits once set stay set until software rewrites them.
- R4: trapPulse is high for the one cycle after an operation-done cycle without a software write in which opFlags ANDed with status bits 4:0 (the enables, as held before the update) is nonzero. Otherwise trapPulse is low.
- R5: An operation-done cycle with all flags zero, or a cycle with no strobe at all, leaves the status word unchanged and raises no trap.
- R6: A software write loads swWrData into the word on the next edge. Any operation or compare strobe in the same cycle is ignored, and no trap follows.
- R7: The compare outcome is cmpMask bit 4 for greater (cmpRel 0), bit 3 for less (cmpRel 1), bit 2 for equal (cmpRel 2) and bit 1 for unordered (cmpRel 3).
- R8: A compare with cmpTarget y in 1..7 sets status bit 22-y to the outcome and leaves all other bits unchanged.
- R9: A compare with cmpTarget 0 moves bits 21:12 down into bits 20:11, moves the old bit 26 into bit 21, and writes the outcome into bit 26. Old bit 11 is dropped and all other bits are kept.
- R10: When operation-done and compare-done coincide, the flag merge and the compare update are both applied in the same cycle. The flag merge is applied first.
- R11: cmpSignaling combinationally equals cmpMask bit 0, which marks a signalling compare rather than a quiet one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 32 | Value loaded by a software write |
| opDone | input | 1 | Arithmetic operation finished |
| opFlags | input | 5 | Exception flags of the finished operation |
| cmpDone | input | 1 | Compare finished |
| cmpRel | input | 2 | Relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmpMask | input | 5 | Condition mask of the compare |
| cmpTarget | input | 3 | Target condition index; 0 selects the queue |
| statusReg | output | 32 | Current status word |
| roundMode | output | 2 | Decoded rounding direction |
| flushZero | output | 1 | Decoded flush-to-zero control |
| cmpSignaling | output | 1 | Compare is of the signalling kind |
| trapPulse | output | 1 | One-cycle exception trap |

## Verification
The assertions take for granted that the only ways the word changes are a software write, a flag merge or a compare. They check at the ports that the enable bits 4:0 never move without a write. They also check that sticky flag bits never fall without a write, and that an idle cycle keeps the word. The stimulus keeps every input driven and known outside reset and changes inputs only between edges. After each software write the bench starts from a known word, so that the sweeps over flags, enables, relations, masks and targets are each compared with an arithmetic model of the next word.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int REG_W   = 32;
  localparam int FLAG_N  = 5;
  localparam int MASK_W  = 5;
  localparam int TGT_W   = 3;
  localparam int REL_W   = 2;
  localparam int RND_W   = 2;
  localparam int FLAG_LSB = REG_W - FLAG_N;  // sticky flags occupy the top bits
  localparam int RND_LSB  = 9;
  localparam int FTZ_BIT  = 5;
  localparam int ENA_LSB  = 0;
  localparam int Q_HEAD   = 26;             // most recent compare outcome
  localparam int Q_TOP    = 21;             // first queue slot / first target bit
  localparam int Q_LOW    = 11;             // last queue slot
  localparam int Q_LEN    = Q_TOP - Q_LOW;  // slots that shift down
  localparam int TGT_N    = 1 << TGT_W;

  typedef enum logic [REL_W-1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } relT;

  typedef struct packed {
    logic load;
    logic mergeFlags;
    logic cmpWrite;
    logic cmpQueued;
    logic outcome;
  } strobeT;
endpackage

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWrEn,
  input  logic              opDone,
  input  logic [FLAG_N-1:0] opFlags,
  input  logic              cmpDone,
  input  logic [REL_W-1:0]  cmpRel,
  input  logic [MASK_W-1:0] cmpMask,
  input  logic [TGT_W-1:0]  cmpTarget,
  input  logic [FLAG_N-1:0] enables,
  output strobeT            strobes,
  output logic              cmpSignaling,
  output logic              trapPulse
);
  logic pickedOutcome;
  logic trapNow;

  always_comb begin
    unique case (relT'(cmpRel))
      REL_GT:  pickedOutcome = cmpMask[4];
      REL_LT:  pickedOutcome = cmpMask[3];
      REL_EQ:  pickedOutcome = cmpMask[2];
      default: pickedOutcome = cmpMask[1];
    endcase
  end

  always_comb begin
    strobes.load       = swWrEn;
    strobes.mergeFlags = !swWrEn && opDone && (opFlags != '0);
    strobes.cmpWrite   = !swWrEn && cmpDone;
    strobes.cmpQueued  = (cmpTarget == '0);
    strobes.outcome    = pickedOutcome;
  end

  assign trapNow      = strobes.mergeFlags && ((opFlags & enables) != '0);
  assign cmpSignaling = cmpMask[0];

  always_ff @(posedge clk) begin
    if (!rstN) trapPulse <= 1'b0;
    else       trapPulse <= trapNow;
  end
endmodule

// File: rtl/fpsr_datapath.sv
module fpsr_datapath
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [REG_W-1:0]  swWrData,
  input  logic [FLAG_N-1:0] opFlags,
  input  logic [TGT_W-1:0]  cmpTarget,
  output logic [REG_W-1:0]  statusReg,
  output logic [FLAG_N-1:0] enables,
  output logic [RND_W-1:0]  roundMode,
  output logic              flushZero
);
  logic [REG_W-1:0] afterFlags;
  logic [REG_W-1:0] afterCmp;
  logic [REG_W-1:0] nextReg;
  logic [TGT_N-1:0] tgtHit;

  // one decoder line per targeted condition bit
  for (genvar t = 0; t < TGT_N; t++) begin : g_tgt
    assign tgtHit[t] = (cmpTarget == TGT_W'(t));
  end

  always_comb begin
    afterFlags = statusReg;
    if (strobes.mergeFlags)
      afterFlags[FLAG_LSB +: FLAG_N] = statusReg[FLAG_LSB +: FLAG_N] | opFlags;
  end

  always_comb begin
    afterCmp = afterFlags;
    if (strobes.cmpWrite) begin
      if (strobes.cmpQueued) begin
        afterCmp[Q_LOW +: Q_LEN] = afterFlags[Q_LOW+1 +: Q_LEN];
        afterCmp[Q_TOP]          = afterFlags[Q_HEAD];
        afterCmp[Q_HEAD]         = strobes.outcome;
      end else begin
        for (int t = 1; t < TGT_N; t++)
          if (tgtHit[t]) afterCmp[Q_TOP + 1 - t] = strobes.outcome;
      end
    end
  end

  assign nextReg = strobes.load ? swWrData : afterCmp;

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= nextReg;
  end

  assign enables   = statusReg[ENA_LSB +: FLAG_N];
  assign roundMode = statusReg[RND_LSB +: RND_W];
  assign flushZero = statusReg[FTZ_BIT];
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWrEn,
  input  logic [REG_W-1:0]  swWrData,
  input  logic              opDone,
  input  logic [FLAG_N-1:0] opFlags,
  input  logic              cmpDone,
  input  logic [REL_W-1:0]  cmpRel,
  input  logic [MASK_W-1:0] cmpMask,
  input  logic [TGT_W-1:0]  cmpTarget,
  output logic [REG_W-1:0]  statusReg,
  output logic [RND_W-1:0]  roundMode,
  output logic              flushZero,
  output logic              cmpSignaling,
  output logic              trapPulse
);
  strobeT            strobes;
  logic [FLAG_N-1:0] enables;

  fpsr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .opDone(opDone), .opFlags(opFlags),
    .cmpDone(cmpDone), .cmpRel(cmpRel), .cmpMask(cmpMask), .cmpTarget(cmpTarget),
    .enables(enables), .strobes(strobes), .cmpSignaling(cmpSignaling),
    .trapPulse(trapPulse)
  );

  fpsr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .swWrData(swWrData),
    .opFlags(opFlags), .cmpTarget(cmpTarget), .statusReg(statusReg),
    .enables(enables), .roundMode(roundMode), .flushZero(flushZero)
  );
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker
  import fpsr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              swWrEn,
  input logic [REG_W-1:0]  swWrData,
  input logic              opDone,
  input logic              cmpDone,
  input logic [REG_W-1:0]  statusReg,
  input logic              trapPulse
);
  // R6: a software write lands verbatim
  p_sw_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> statusReg == $past(swWrData));

  // R6: no trap after a write cycle
  p_sw_no_trap_r6: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> !trapPulse);

  // R4: trap only after an operation-done cycle
  p_trap_needs_op_r4: assert property (@(posedge clk) disable iff (!rstN)
    !opDone |=> !trapPulse);

  // R3: sticky flags never fall without a write
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> (statusReg[REG_W-1 -: FLAG_N] & $past(statusReg[REG_W-1 -: FLAG_N]))
                == $past(statusReg[REG_W-1 -: FLAG_N]));

  // R8: enables are touched only by software
  p_enables_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> $stable(statusReg[FLAG_N-1:0]));

  // R5: an idle cycle keeps the word
  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrEn && !opDone && !cmpDone) |=> $stable(statusReg));
endmodule

bind fpsr_unit fpsr_checker u_chk (
  .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
  .opDone(opDone), .cmpDone(cmpDone), .statusReg(statusReg), .trapPulse(trapPulse)
);

// File: tb/tb_fpsr_unit.sv
`timescale 1ns/1ps
module tb_fpsr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic        opDone = 1'b0;
  logic [4:0]  opFlags = '0;
  logic        cmpDone = 1'b0;
  logic [1:0]  cmpRel = '0;
  logic [4:0]  cmpMask = '0;
  logic [2:0]  cmpTarget = '0;
  logic [31:0] statusReg;
  logic [1:0]  roundMode;
  logic        flushZero;
  logic        cmpSignaling;
  logic        trapPulse;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = '0;
  logic        modelTrap = 1'b0;

  always #5 clk = ~clk;

  fpsr_unit dut (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
    .opDone(opDone), .opFlags(opFlags), .cmpDone(cmpDone), .cmpRel(cmpRel),
    .cmpMask(cmpMask), .cmpTarget(cmpTarget), .statusReg(statusReg),
    .roundMode(roundMode), .flushZero(flushZero), .cmpSignaling(cmpSignaling),
    .trapPulse(trapPulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // next word computed from the requirement text
  function automatic logic [31:0] nextWord(logic [31:0] w, logic wr, logic [31:0] wd,
      logic op, logic [4:0] fl, logic cd, logic [1:0] rel, logic [4:0] mk, logic [2:0] y);
    logic [31:0] n;
    logic o;
    if (wr) return wd;
    n = w;
    if (op) n = n | ({27'd0, fl} << 27);
    if (cd) begin
      o = mk[4 - rel];
      if (y != 0) n[22 - y] = o;
      else begin
        for (int b = 11; b <= 20; b++) n[b] = w[b+1];
        n[21] = n[26];
        n[26] = o;
      end
    end
    return n;
  endfunction

  task automatic step(string req, logic wr, logic [31:0] wd, logic op, logic [4:0] fl,
                      logic cd, logic [1:0] rel, logic [4:0] mk, logic [2:0] y);
    @(negedge clk);
    swWrEn = wr; swWrData = wd; opDone = op; opFlags = fl;
    cmpDone = cd; cmpRel = rel; cmpMask = mk; cmpTarget = y;
    modelTrap = !wr && op && ((fl & model[4:0]) != 0);
    model = nextWord(model, wr, wd, op, fl, cd, rel, mk, y);
    @(posedge clk);
    #2;
    check(req, statusReg, model);
    check({req, " trap"}, {31'd0, trapPulse}, {31'd0, modelTrap});
  endtask

  task automatic write(logic [31:0] v);
    step("R6", 1'b1, v, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 3'd0);
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 32'd0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 3'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset word", statusReg, 32'd0);
    check("R1 reset trap", {31'd0, trapPulse}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 after release", statusReg, 32'd0);

    // R2 decode sweep
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++) begin
        write((32'(m) << 9) | (32'(f) << 5) | 32'h0000_4001);
        check("R2 roundMode", {30'd0, roundMode}, 32'(m));
        check("R2 flushZero", {31'd0, flushZero}, 32'(f));
      end

    // R3 / R4 flags and enables sweep
    for (int e = 0; e < 4; e++) begin
      logic [4:0] en;
      en = (e == 0) ? 5'h00 : (e == 1) ? 5'h15 : (e == 2) ? 5'h0A : 5'h1F;
      for (int fl = 0; fl < 32; fl++) begin
        write({27'h0123456, en} & 32'h07FF_FFFF);
        step("R3 R4 flags", 1'b0, 32'd0, 1'b1, 5'(fl), 1'b0, 2'd0, 5'd0, 3'd0);
        idle("R4 pulse ends");
      end
    end

    // R3 accumulation
    write(32'h0000_0000);
    for (int b = 0; b < 5; b++)
      step("R3 sticky accumulate", 1'b0, 32'd0, 1'b1, 5'(1 << b), 1'b0, 2'd0, 5'd0, 3'd0);

    // R5 no flags, no strobes
    write(32'h5A5A_5A5F);
    step("R5 zero flags", 1'b0, 32'd0, 1'b1, 5'd0, 1'b0, 2'd0, 5'd0, 3'd0);
    idle("R5 idle");

    // R7 / R8 targeted compare sweep
    for (int y = 1; y < 8; y++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 4; k++) begin
          logic [4:0] mk;
          mk = (k == 0) ? 5'b10100 : (k == 1) ? 5'b01011 : (k == 2) ? 5'b11110 : 5'b00000;
          write((k[0]) ? 32'hFFFF_FFFF : 32'h0000_0000);
          step("R7 R8 targeted", 1'b0, 32'd0, 1'b0, 5'd0, 1'b1, 2'(r), mk, 3'(y));
        end

    // R9 queued compares with a walking pattern
    write(32'hA5C3_9E71);
    for (int i = 0; i < 24; i++)
      step("R9 queue shift", 1'b0, 32'd0, 1'b0, 5'd0, 1'b1, 2'(i % 4),
           5'(i * 7 + 3), 3'd0);

    // R6 write priority over both strobes
    write(32'h0000_001F);
    step("R6 write wins", 1'b1, 32'h1234_5670, 1'b1, 5'h1F, 1'b1, 2'd0, 5'h1F, 3'd0);

    // R10 flag merge plus compare in one cycle
    for (int y = 0; y < 8; y++) begin
      write(32'h0400_0013);
      step("R10 combined", 1'b0, 32'd0, 1'b1, 5'h15, 1'b1, 2'd1, 5'b01000, 3'(y));
    end

    // R11 signalling select
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      cmpMask = 5'(k);
      #1;
      check("R11 cmpSignaling", {31'd0, cmpSignaling}, 32'(k & 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule